// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Control

This block keeps a 2,048-row DRAM refreshed without supplying row addresses. A free-running interval counter marks a refresh as due every `INTERVAL` clocks; the default of 1,560 clocks gives one refresh every 15.6 us at 100 MHz, so that every row is visited within 32 ms. A due refresh raises a request to the access sequencer. Once the grant comes back, the block owns the strobes and plays a CAS-before-RAS sequence: CAS drops first, RAS follows, both are held for a fixed width, then both return high for a precharge gap. Because CAS is already low when RAS falls, the device takes the row from its own internal counter. Write enable and output enable are never asserted, so no data moves and the data pins stay high-impedance.

When the access sequencer keeps the grant away, due refreshes are counted up to `MAX_PEND`. When the grant returns, they are issued back to back without releasing ownership. When the host raises a low-power level, the block starts the same CAS-first entry and then keeps RAS low, which puts the device into self-refresh. RAS stays low for at least `T_SRMIN` clocks and for as long as the level is held. On exit, RAS is held high for `T_SREXIT` clocks. A status output is high for the whole retention period. After exit, the count of owed refreshes is empty and the interval restarts, so refreshes resume one at a time on the normal schedule.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rstN` is low, `rasN` and `casN` are high, `refReq` is low and `selfRefActive` is low.
- R2: A refresh becomes due every `INTERVAL` clocks. With `grant` held high, successive RAS falling edges of ordinary refreshes are exactly `INTERVAL` clocks apart.
- R3: `refReq` is high from the cycle after work becomes due until ownership ends. `rasN` and `casN` stay high whenever `refReq` is low or the grant has not yet been taken. A strobe sequence starts only in the cycle after one in which `grant` was sampled high.
- R4: Each RAS fall is preceded by exactly `T_CSU` cycles with CAS low and RAS high (CAS-before-RAS ordering). `weN` and `oeN` are high in every cycle.
- R5: In an ordinary refresh, RAS is low for exactly `T_RAS` cycles while CAS is low. RAS and CAS are then both high for `T_PRE` cycles before any following CAS fall.
- R6: Dropping `grant` after a sequence has started neither shortens nor aborts it. The block then waits with `refReq` high and the strobes high.
- R7: At most `MAX_PEND` refreshes are owed; further intervals that expire while the count is full are dropped. When the grant arrives, the owed refreshes are issued back to back. Consecutive RAS falls are then `T_CSU+T_RAS+T_PRE` cycles apart.
- R8: `lowPowerReq` takes priority over owed refreshes. Self-refresh entry is a CAS-first sequence of `T_CSU` cycles followed by RAS low, and `selfRefActive` rises in the same cycle RAS falls.
- R9: During self-refresh, RAS stays low for at least `T_SRMIN` cycles (exactly `T_SRMIN` if `lowPowerReq` drops earlier), and for as long as `lowPowerReq` stays high.
- R10: On exit, RAS and CAS are both high for exactly `T_SREXIT` cycles with `selfRefActive` still high; `selfRefActive` then falls.
- R11: After self-refresh exit, the owed count is zero and the interval restarts. With the grant high, the first RAS fall comes `INTERVAL+2+T_CSU` cycles after `selfRefActive` falls, and no burst occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Access sequencer hands over the strobes |
| lowPowerReq | input | 1 | Host level asking for self-refresh retention |
| refReq | output | 1 | Block wants, or holds, ownership of the strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, held inactive high |
| oeN | output | 1 | Output enable, held inactive high |
| selfRefActive | output | 1 | Device is in, or leaving, self-refresh |

## Verification
Every delay has a known count of registers. An interval expiry becomes a request two cycles later. A taken grant drops CAS on the next edge. RAS falls `T_CSU` cycles after CAS falls, and after self-refresh exit the first RAS fall lands `INTERVAL+2+T_CSU` cycles after the status falls. The bench samples the pins at the falling clock edge and timestamps every strobe edge with a cycle number. Each check compares differences between these timestamps, or measured run lengths, against the expected arithmetic, so no check depends on where in a cycle a stimulus landed. Grant and low-power changes are driven just after a falling edge, and each check waits until its due cycle before reading the timestamps.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CSU,
    ST_RLOW,
    ST_PRE,
    ST_SRLOW,
    ST_SREXIT
  } rfshState_e;

  typedef enum logic [2:0] {
    TM_CSU,
    TM_RAS,
    TM_PRE,
    TM_SRMIN,
    TM_SREXIT
  } tmrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    take;     // one owed refresh is being issued
    logic    srHold;   // self-refresh: clear owed count, park interval
    logic    tmrLoad;  // load the phase timer
    tmrSel_e tmrSel;   // which phase length to load
  } rfshStrb_t;

endpackage

// File: rtl/dram_refresh_dp.sv
module dram_refresh_dp
  import dram_refresh_pkg::*;
#(
  parameter int INTERVAL = 1560,
  parameter int MAX_PEND = 4,
  parameter int T_CSU    = 2,
  parameter int T_RAS    = 5,
  parameter int T_PRE    = 4,
  parameter int T_SRMIN  = 10,
  parameter int T_SREXIT = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  rfshStrb_t strb,
  output logic      pendNz,
  output logic      tmrDone
);

  localparam int IW   = $clog2(INTERVAL);
  localparam int PW   = $clog2(MAX_PEND + 1);
  localparam int M1   = (T_CSU > T_RAS) ? T_CSU : T_RAS;
  localparam int M2   = (M1 > T_PRE) ? M1 : T_PRE;
  localparam int M3   = (M2 > T_SRMIN) ? M2 : T_SRMIN;
  localparam int TMAX = (M3 > T_SREXIT) ? M3 : T_SREXIT;
  localparam int TW   = $clog2(TMAX + 1);

  localparam logic [IW-1:0] INT_LAST = IW'(INTERVAL - 1);
  localparam logic [PW-1:0] PEND_TOP = PW'(MAX_PEND);

  logic [IW-1:0] intvCnt;
  logic [PW-1:0] pendCnt;
  logic [TW-1:0] tmrCnt;
  logic [TW-1:0] tmrLd;
  logic          tick;

  assign tick    = (intvCnt == INT_LAST);
  assign pendNz  = (pendCnt != '0);
  assign tmrDone = (tmrCnt == '0);

  // interval counter and owed-refresh count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intvCnt <= '0;
      pendCnt <= '0;
    end else if (strb.srHold) begin
      intvCnt <= '0;
      pendCnt <= '0;
    end else begin
      intvCnt <= tick ? '0 : intvCnt + 1'b1;
      case ({tick, strb.take})
        2'b10:   if (pendCnt != PEND_TOP) pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // phase length select
  always_comb begin
    case (strb.tmrSel)
      TM_CSU:    tmrLd = TW'(T_CSU - 1);
      TM_RAS:    tmrLd = TW'(T_RAS - 1);
      TM_PRE:    tmrLd = TW'(T_PRE - 1);
      TM_SRMIN:  tmrLd = TW'(T_SRMIN - 1);
      TM_SREXIT: tmrLd = TW'(T_SREXIT - 1);
      default:   tmrLd = '0;
    endcase
  end

  // shared phase timer, sticks at zero
  always_ff @(posedge clk) begin
    if (!rstN)            tmrCnt <= '0;
    else if (strb.tmrLoad) tmrCnt <= tmrLd;
    else if (!tmrDone)    tmrCnt <= tmrCnt - 1'b1;
  end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_refresh_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      grant,
  input  logic      lowPowerReq,
  input  logic      pendNz,
  input  logic      tmrDone,
  output rfshStrb_t strb,
  output logic      refReq,
  output logic      rasN,
  output logic      casN,
  output logic      selfRefActive
);

  rfshState_e state, nxt;
  logic       srMode, srModeNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      srMode <= 1'b0;
    end else begin
      state  <= nxt;
      srMode <= srModeNxt;
    end
  end

  always_comb begin
    nxt          = state;
    srModeNxt    = srMode;
    strb.take    = 1'b0;
    strb.tmrLoad = 1'b0;
    strb.tmrSel  = TM_CSU;
    strb.srHold  = srMode && (state inside {ST_CSU, ST_SRLOW, ST_SREXIT});
    case (state)
      ST_IDLE: begin
        srModeNxt = 1'b0;
        if (lowPowerReq || pendNz) nxt = ST_REQ;
      end
      ST_REQ: begin
        if (grant && lowPowerReq) begin
          nxt          = ST_CSU;
          srModeNxt    = 1'b1;
          strb.tmrLoad = 1'b1;
        end else if (grant && pendNz) begin
          nxt          = ST_CSU;
          srModeNxt    = 1'b0;
          strb.take    = 1'b1;
          strb.tmrLoad = 1'b1;
        end else if (!lowPowerReq && !pendNz) begin
          nxt = ST_IDLE;
        end
      end
      ST_CSU: begin
        if (tmrDone) begin
          nxt          = srMode ? ST_SRLOW : ST_RLOW;
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = srMode ? TM_SRMIN : TM_RAS;
        end
      end
      ST_RLOW: begin
        if (tmrDone) begin
          nxt          = ST_PRE;
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = TM_PRE;
        end
      end
      ST_PRE: begin
        if (tmrDone) begin
          if (grant && pendNz && !lowPowerReq) begin
            nxt          = ST_CSU;
            strb.take    = 1'b1;
            strb.tmrLoad = 1'b1;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_SRLOW: begin
        if (tmrDone && !lowPowerReq) begin
          nxt          = ST_SREXIT;
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = TM_SREXIT;
        end
      end
      ST_SREXIT: begin
        if (tmrDone) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign refReq        = (state != ST_IDLE);
  assign rasN          = !(state inside {ST_RLOW, ST_SRLOW});
  assign casN          = !(state inside {ST_CSU, ST_RLOW, ST_SRLOW});
  assign selfRefActive = (state inside {ST_SRLOW, ST_SREXIT});

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int INTERVAL = 1560,
  parameter int MAX_PEND = 4,
  parameter int T_CSU    = 2,
  parameter int T_RAS    = 5,
  parameter int T_PRE    = 4,
  parameter int T_SRMIN  = 10,
  parameter int T_SREXIT = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic grant,
  input  logic lowPowerReq,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic oeN,
  output logic selfRefActive
);

  rfshStrb_t strb;
  logic      pendNz;
  logic      tmrDone;

  dram_refresh_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .grant        (grant),
    .lowPowerReq  (lowPowerReq),
    .pendNz       (pendNz),
    .tmrDone      (tmrDone),
    .strb         (strb),
    .refReq       (refReq),
    .rasN         (rasN),
    .casN         (casN),
    .selfRefActive(selfRefActive)
  );

  dram_refresh_dp #(
    .INTERVAL(INTERVAL),
    .MAX_PEND(MAX_PEND),
    .T_CSU   (T_CSU),
    .T_RAS   (T_RAS),
    .T_PRE   (T_PRE),
    .T_SRMIN (T_SRMIN),
    .T_SREXIT(T_SREXIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pendNz (pendNz),
    .tmrDone(tmrDone)
  );

  assign weN = 1'b1;
  assign oeN = 1'b1;

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int T_RAS    = 5,
  parameter int T_SRMIN  = 10,
  parameter int T_SREXIT = 12
) (
  input logic clk,
  input logic rstN,
  input logic grant,
  input logic refReq,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic oeN,
  input logic selfRefActive
);

  logic [15:0] rasLowCnt;
  logic [15:0] srHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasLowCnt <= '0;
      srHighCnt <= '0;
    end else begin
      if (!rasN) begin
        if (rasLowCnt != '1) rasLowCnt <= rasLowCnt + 1'b1;
      end else begin
        rasLowCnt <= '0;
      end
      if (selfRefActive && rasN) srHighCnt <= srHighCnt + 1'b1;
      else if (!selfRefActive)   srHighCnt <= '0;
    end
  end

  p_quiet_without_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    !refReq |-> (rasN && casN));

  p_start_after_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && rasN) |-> $past(grant));

  p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  p_no_data_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    weN && oeN);

  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rasN) && !selfRefActive) |-> (rasLowCnt == 16'(T_RAS)));

  p_sr_enter_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfRefActive) |-> (!rasN && !casN));

  p_sr_min_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rasN) && selfRefActive) |-> (rasLowCnt >= 16'(T_SRMIN)));

  p_sr_exit_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selfRefActive) |-> (srHighCnt == 16'(T_SREXIT)));

endmodule

bind dram_refresh_sched dram_refresh_chk #(
  .T_RAS   (T_RAS),
  .T_SRMIN (T_SRMIN),
  .T_SREXIT(T_SREXIT)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .grant        (grant),
  .refReq       (refReq),
  .rasN         (rasN),
  .casN         (casN),
  .weN          (weN),
  .oeN          (oeN),
  .selfRefActive(selfRefActive)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;

  localparam int I     = 40;
  localparam int MP    = 3;
  localparam int TCSU  = 2;
  localparam int TRAS  = 4;
  localparam int TPRE  = 3;
  localparam int TSMIN = 6;
  localparam int TSEX  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grant = 1'b0;
  logic lowPowerReq = 1'b0;
  logic refReq, rasN, casN, weN, oeN, selfRefActive;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .INTERVAL(I), .MAX_PEND(MP), .T_CSU(TCSU), .T_RAS(TRAS),
    .T_PRE(TPRE), .T_SRMIN(TSMIN), .T_SREXIT(TSEX)
  ) u0 (
    .clk(clk), .rstN(rstN), .grant(grant), .lowPowerReq(lowPowerReq),
    .refReq(refReq), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .selfRefActive(selfRefActive)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  // edge monitor, sampled at the falling clock edge
  int cyc = 0;
  int fallCyc[64];
  int setupLen[64];
  int gapLen[64];
  bit selfAtFall[64];
  int lowLen[64];
  int nFall = 0, nRise = 0;
  int csCnt = 0, lowCnt = 0, bhCnt = 0, srHiCnt = 0, lastGap = 0;
  int exitLen = 0, sfFallCyc = 0, badEnable = 0;
  logic pRas = 1'b1, pCas = 1'b1, pSelf = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      cyc = cyc + 1;
      if (!(weN && oeN)) badEnable = badEnable + 1;
      if (pCas && !casN) lastGap = bhCnt;
      if (pRas && !rasN && nFall < 64) begin
        fallCyc[nFall]    = cyc;
        setupLen[nFall]   = csCnt;
        gapLen[nFall]     = lastGap;
        selfAtFall[nFall] = selfRefActive;
        nFall = nFall + 1;
      end
      if (!pRas && rasN && nRise < 64) begin
        lowLen[nRise] = lowCnt;
        nRise = nRise + 1;
      end
      if (pSelf && !selfRefActive) begin
        exitLen   = srHiCnt;
        sfFallCyc = cyc;
      end
      csCnt   = (!casN && rasN) ? csCnt + 1 : 0;
      lowCnt  = !rasN ? lowCnt + 1 : 0;
      bhCnt   = (rasN && casN) ? bhCnt + 1 : 0;
      srHiCnt = (selfRefActive && rasN) ? srHiCnt + 1 : 0;
      pRas = rasN; pCas = casN; pSelf = selfRefActive;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk = nChk + 1;
    if (!ok) begin
      nFail = nFail + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic waitFalls(input int n);
    while (nFall < n) step(1);
  endtask

  initial begin
    int base, r, s;
    step(3);
    // R1: reset state
    chk(rasN === 1'b1 && casN === 1'b1, "R1 strobes high in reset", {rasN, casN}, 3);
    chk(refReq === 1'b0, "R1 refReq low in reset", refReq, 0);
    chk(selfRefActive === 1'b0, "R1 status low in reset", selfRefActive, 0);
    rstN = 1'b1;

    // R3/R7: no grant for four intervals, backlog saturates
    step(4 * I + 5);
    chk(refReq === 1'b1, "R3 request held while grant absent", refReq, 1);
    chk(nFall == 0 && rasN && casN, "R3 no strobes without grant", nFall, 0);
    base = cyc;
    grant = 1'b1;
    step(33);
    chk(nFall == MP, "R7 back-to-back count saturates", nFall, MP);
    chk(setupLen[0] == TCSU, "R4 CAS setup before RAS", setupLen[0], TCSU);
    chk(lowLen[0] == TRAS, "R5 RAS low width", lowLen[0], TRAS);
    chk(gapLen[1] == TPRE, "R5 precharge gap", gapLen[1], TPRE);
    chk(gapLen[2] == TPRE, "R7 precharge gap in burst", gapLen[2], TPRE);
    chk(fallCyc[1] - fallCyc[0] == TCSU + TRAS + TPRE, "R7 burst spacing",
        fallCyc[1] - fallCyc[0], TCSU + TRAS + TPRE);
    chk(fallCyc[2] - fallCyc[1] == TCSU + TRAS + TPRE, "R7 burst spacing",
        fallCyc[2] - fallCyc[1], TCSU + TRAS + TPRE);
    chk(fallCyc[0] - base <= TCSU + 2, "R3 start follows grant",
        fallCyc[0] - base, TCSU + 2);

    // R2: steady periodic refresh
    waitFalls(6);
    chk(fallCyc[4] - fallCyc[3] == I, "R2 interval spacing", fallCyc[4] - fallCyc[3], I);
    chk(fallCyc[5] - fallCyc[4] == I, "R2 interval spacing", fallCyc[5] - fallCyc[4], I);

    // R6: withdraw grant once CAS has dropped
    while (!(casN == 1'b0 && rasN == 1'b1)) step(1);
    grant = 1'b0;
    r = nRise;
    while (nRise <= r) step(1);
    chk(lowLen[r] == TRAS, "R6 sequence completes after grant drop", lowLen[r], TRAS);
    step(I + 10);
    chk(refReq === 1'b1 && rasN && casN, "R6 waits with request high",
        {refReq, rasN, casN}, 7);
    grant = 1'b1;
    step(20);

    // R8-R11: short self-refresh
    lowPowerReq = 1'b1;
    while (!selfRefActive) step(1);
    s = nFall - 1;
    chk(selfAtFall[s] == 1'b1, "R8 status rises with RAS fall", selfAtFall[s], 1);
    chk(setupLen[s] == TCSU, "R8 CAS-first entry", setupLen[s], TCSU);
    lowPowerReq = 1'b0;
    r = nRise;
    while (selfRefActive) step(1);
    chk(lowLen[r] == TSMIN, "R9 minimum RAS low hold", lowLen[r], TSMIN);
    chk(exitLen == TSEX, "R10 exit precharge", exitLen, TSEX);
    s = nFall;
    waitFalls(s + 2);
    chk(fallCyc[s] - sfFallCyc == I + 2 + TCSU, "R11 first refresh after exit",
        fallCyc[s] - sfFallCyc, I + 2 + TCSU);
    chk(fallCyc[s + 1] - fallCyc[s] == I, "R11 no burst after exit",
        fallCyc[s + 1] - fallCyc[s], I);

    // R9-R11: long self-refresh
    lowPowerReq = 1'b1;
    while (!selfRefActive) step(1);
    r = nRise;
    step(200);
    chk(!rasN && !casN && nRise == r, "R9 RAS held low while requested",
        nRise - r, 0);
    lowPowerReq = 1'b0;
    while (selfRefActive) step(1);
    chk(lowLen[r] >= 200, "R9 long hold length", lowLen[r], 200);
    chk(exitLen == TSEX, "R10 exit precharge after long hold", exitLen, TSEX);
    s = nFall;
    waitFalls(s + 1);
    chk(fallCyc[s] - sfFallCyc == I + 2 + TCSU, "R11 resume schedule after long hold",
        fallCyc[s] - sfFallCyc, I + 2 + TCSU);
    chk(badEnable == 0, "R4 WE and OE never active", badEnable, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk = nChk + 1;
      nFail = nFail + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule